// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block holds the memory window registers of a bridge between a primary bus and two secondary buses. It decides, for any 32-bit memory address it is shown, whether the address falls inside the forwarding window. The window is set in 1 MB steps. A 12-bit base field gives the bottom of the window with address bits 19:0 taken as zero. A 12-bit limit field gives the top with address bits 19:0 taken as all ones. The forward decision is combinational from the address and the stored fields.

The block also keeps five sticky error flags shared by the two secondary interfaces. Each flag is set by a one-clock event pulse from either interface and cleared by software writing a one to it.

Software reaches both registers through a dword port with per-byte enables. `reg_sel` picks the register: 1 selects the window register and 0 selects the status word. Reads are combinational from the selected register.

Top module: `mwin_top`

## Requirements
- R1: After reset, the base field, the limit field and all five status flags are zero. With both fields zero, addresses 00000000h to 000FFFFFh are forwarded.
- R2: In the window register, bits 15:4 hold the writable base field (address bits 31:20 of the bottom) and bits 3:0 always read zero.
- R3: In the window register, bits 31:20 hold the writable limit field (address bits 31:20 of the top) and bits 19:16 always read zero.
- R4: `fwd_hit` is 1 exactly when {base, 00000h} <= address <= {limit, FFFFFh}. Both ends are inclusive, and the output is combinational from the address.
- R5: When base > limit, no address is forwarded.
- R6: A window write updates only the enabled bytes. Byte 0 carries base bits 3:0 (from data bits 7:4), byte 1 carries base bits 11:4, byte 2 carries limit bits 3:0 (from data bits 23:20), and byte 3 carries limit bits 11:4.
- R7: Status flags sit at bit 27 (target abort signalled), bit 28 (target abort received), bit 29 (master abort received), bit 30 (system error) and bit 31 (parity error). A pulse from either secondary port sets the flag on the next edge. The same event from both ports in one cycle simply sets it. Bits 26:0 read zero.
- R8: A status write with byte enable 3 set clears each flag whose data bit is one. Flags written with zero, or written with byte enable 3 clear, keep their value.
- R9: If an event and a clear hit the same flag in one cycle, the flag ends up set.
- R10: A write with `reg_sel`=1 never changes the status flags, and a write with `reg_sel`=0 never changes the window fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 = window register, 0 = status word |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables |
| reg_rdata | output | 32 | Read data of the selected register |
| ev_sig_tabort | input | 2 | Per port: target abort signalled |
| ev_rcv_tabort | input | 2 | Per port: target abort received |
| ev_rcv_mabort | input | 2 | Per port: master abort received |
| ev_serr | input | 2 | Per port: system error seen |
| ev_perr | input | 2 | Per port: parity error seen |
| probe_addr | input | 32 | Memory address to decode |
| fwd_hit | output | 1 | Address lies inside the window |
| status_word | output | 32 | Status flags, live |

## Verification
The assertions take the event inputs to be one-clock pulses, one per occurrence. A flag is therefore expected set on the edge after any pulse, whatever is written in the same cycle. They also take every register write to be a single-cycle strobe with the select and byte enables valid alongside it.

The stimulus drives all inputs away from the clock edge and keeps events sparse. It mixes writes to both registers under random byte enables. Probe addresses are drawn close to the current base and limit, including the exact 1 MB boundaries. Directed cases cover the inclusive ends, an empty window, a clear colliding with an event, and the same event arriving on both ports at once.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int ADDR_W = 32;
  localparam int GRAN_W = 20;
  localparam int FLD_W  = ADDR_W - GRAN_W;
  localparam int N_EV   = 5;
  localparam int STAT_LSB = 27;

  // inclusive window test over full addresses
  function automatic logic win_hit(input logic [FLD_W-1:0] base,
                                   input logic [FLD_W-1:0] limit,
                                   input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-1:0] lo, hi;
    lo = {base, {GRAN_W{1'b0}}};
    hi = {limit, {GRAN_W{1'b1}}};
    return (addr >= lo) && (addr <= hi);
  endfunction

  // next status: clear first, then events override
  function automatic logic [N_EV-1:0] stat_next(input logic [N_EV-1:0] cur,
                                                input logic [N_EV-1:0] clr,
                                                input logic [N_EV-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/mwin_regs.sv
module mwin_regs
  import mwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_we,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be,
  output logic [FLD_W-1:0] base,
  output logic [FLD_W-1:0] limit
);
  logic unused_bits;
  assign unused_bits = ^{wdata[19:16], wdata[3:0]};

  logic [FLD_W-1:0] base_d, limit_d;

  always_comb begin
    base_d  = base;
    limit_d = limit;
    if (be[0]) base_d[3:0]   = wdata[7:4];
    if (be[1]) base_d[11:4]  = wdata[15:8];
    if (be[2]) limit_d[3:0]  = wdata[23:20];
    if (be[3]) limit_d[11:4] = wdata[31:24];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      limit <= '0;
    end else if (win_we) begin
      base  <= base_d;
      limit <= limit_d;
    end
  end

  // R10
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_we |=> ($stable(base) && $stable(limit)));

  // R6
  be_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && !be[3]) |=> $stable(limit[11:4]));
endmodule

// File: rtl/mwin_cmp.sv
module mwin_cmp
  import mwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLD_W-1:0]  base,
  input  logic [FLD_W-1:0]  limit,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = win_hit(base, limit, addr);

  // R5
  empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base > limit) |-> !hit);

  // R4
  hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (addr[ADDR_W-1:GRAN_W] >= base && addr[ADDR_W-1:GRAN_W] <= limit));
endmodule

// File: rtl/mwin_status.sv
module mwin_status
  import mwin_pkg::*;
#(
  parameter int N_PORT = 2
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stat_we,
  input  logic [N_EV-1:0]              clr_bits,
  input  logic [N_PORT-1:0][N_EV-1:0]  ev_in,
  output logic [N_EV-1:0]              flags
);
  logic [N_EV-1:0] ev_any;
  logic [N_EV-1:0] clr_req;

  for (genvar k = 0; k < N_EV; k++) begin : g_merge
    logic [N_PORT-1:0] col;
    for (genvar p = 0; p < N_PORT; p++) begin : g_port
      assign col[p] = ev_in[p][k];
    end
    assign ev_any[k] = |col;
  end

  assign clr_req = stat_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= stat_next(flags, clr_req, ev_any);
  end

  for (genvar k = 0; k < N_EV; k++) begin : g_chk
    // R7 R9
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_any[k] |=> flags[k]);
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !clr_req[k]) |=> flags[k]);
    // R8
    no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[k] && !ev_any[k]) |=> !flags[k]);
  end
endmodule

// File: rtl/mwin_top.sv
module mwin_top
  import mwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_be,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  ev_sig_tabort,
  input  logic [1:0]  ev_rcv_tabort,
  input  logic [1:0]  ev_rcv_mabort,
  input  logic [1:0]  ev_serr,
  input  logic [1:0]  ev_perr,
  input  logic [31:0] probe_addr,
  output logic        fwd_hit,
  output logic [31:0] status_word
);
  localparam int N_PORT = 2;

  logic [FLD_W-1:0] base, limit;
  logic [N_EV-1:0]  flags;
  logic             win_we, stat_we;
  logic [N_PORT-1:0][N_EV-1:0] ev_bus;
  logic [31:0]      win_word;

  assign win_we  = reg_wr && reg_sel;
  assign stat_we = reg_wr && !reg_sel && reg_be[3];

  for (genvar p = 0; p < N_PORT; p++) begin : g_ev
    assign ev_bus[p] = {ev_perr[p], ev_serr[p], ev_rcv_mabort[p],
                        ev_rcv_tabort[p], ev_sig_tabort[p]};
  end

  mwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .win_we(win_we),
    .wdata(reg_wdata), .be(reg_be), .base(base), .limit(limit)
  );

  mwin_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .base(base), .limit(limit),
    .addr(probe_addr), .hit(fwd_hit)
  );

  mwin_status #(.N_PORT(N_PORT)) u_stat (
    .clk(clk), .rst_n(rst_n), .stat_we(stat_we),
    .clr_bits(reg_wdata[31:STAT_LSB]), .ev_in(ev_bus), .flags(flags)
  );

  assign win_word    = {limit, 4'h0, base, 4'h0};
  assign status_word = {flags, {STAT_LSB{1'b0}}};
  assign reg_rdata   = reg_sel ? win_word : status_word;

  // R2 R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[3:0] == 4'h0 && reg_rdata[19:16] == 4'h0));

  // R10
  stat_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && ev_bus == '0) |=> $stable(status_word));
endmodule

// File: tb/test_mwin_top.sv
module test_mwin_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, probe_addr = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_rdata, status_word;
  logic [1:0] ev_sig_tabort = 0, ev_rcv_tabort = 0, ev_rcv_mabort = 0, ev_serr = 0, ev_perr = 0;
  logic fwd_hit;

  int total = 0, bad = 0;
  logic done = 0;
  logic [11:0] mb = 0, ml = 0;
  logic [4:0]  ms = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwin_top i_mwin_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .ev_sig_tabort(ev_sig_tabort), .ev_rcv_tabort(ev_rcv_tabort),
    .ev_rcv_mabort(ev_rcv_mabort), .ev_serr(ev_serr), .ev_perr(ev_perr),
    .probe_addr(probe_addr), .fwd_hit(fwd_hit), .status_word(status_word)
  );

  function automatic logic exp_hit(input logic [11:0] b, l, input logic [31:0] a);
    return (a[31:20] >= b) && (a[31:20] <= l);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, sel, input logic [31:0] wd, input logic [3:0] be,
                      input logic [4:0] e0, e1, input logic [31:0] addr);
    logic [4:0] clr;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; reg_be = be; probe_addr = addr;
    {ev_perr[0], ev_serr[0], ev_rcv_mabort[0], ev_rcv_tabort[0], ev_sig_tabort[0]} = e0;
    {ev_perr[1], ev_serr[1], ev_rcv_mabort[1], ev_rcv_tabort[1], ev_sig_tabort[1]} = e1;
    #1;
    chk("R4/R5 fwd_hit", {31'b0, fwd_hit}, {31'b0, exp_hit(mb, ml, addr)});
    @(posedge clk);
    if (wr && sel) begin
      if (be[0]) mb[3:0]  = wd[7:4];
      if (be[1]) mb[11:4] = wd[15:8];
      if (be[2]) ml[3:0]  = wd[23:20];
      if (be[3]) ml[11:4] = wd[31:24];
    end
    clr = (wr && !sel && be[3]) ? wd[31:27] : 5'b0;
    ms = (ms & ~clr) | e0 | e1;
    #1;
    chk("R7/R8/R9/R10 status", status_word, {ms, 27'b0});
    chk("R2/R3/R6 rdata", reg_rdata, sel ? {ml, 4'h0, mb, 4'h0} : {ms, 27'b0});
  endtask

  task automatic idle(input logic [31:0] addr);
    step(0, 1, 0, 0, 0, 0, addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 status", status_word, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);
    idle(32'h000F_FFFF);
    chk("R1 hit low", {31'b0, fwd_hit}, 32'h1);
    idle(32'h0010_0000);
    chk("R1 miss", {31'b0, fwd_hit}, 32'h0);

    // R2 R3 full write, reserved bits zero
    step(1, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    chk("R2 R3 rsvd", reg_rdata, 32'hFFF0_FFF0);
    step(1, 1, 32'h456A_123B, 4'hF, 0, 0, 0);
    // R4 inclusive ends
    idle(32'h1230_0000);
    idle(32'h122F_FFFF);
    idle(32'h456F_FFFF);
    idle(32'h4570_0000);
    // R6 partial writes
    step(1, 1, 32'hAB00_0000, 4'h8, 0, 0, 0);
    step(1, 1, 32'h0000_00C0, 4'h1, 0, 0, 0);
    chk("R6 partial", reg_rdata, 32'hAB60_12C0);
    // R5 empty window
    step(1, 1, 32'h1000_2000, 4'hF, 0, 0, 0);
    idle(32'h1800_0000);
    idle(32'h2000_0000);
    // R7 events, both ports same event
    step(0, 0, 0, 0, 5'b00101, 5'b00101, 0);
    step(0, 0, 0, 0, 5'b00000, 5'b11000, 0);
    chk("R7 flags", status_word, 32'hE800_0000);
    // R8 write zero and be3 off ignored
    step(1, 0, 32'h0000_0000, 4'hF, 0, 0, 0);
    step(1, 0, 32'hFFFF_FFFF, 4'h7, 0, 0, 0);
    chk("R8 keep", status_word, 32'hE800_0000);
    // R10 window write leaves status
    step(1, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    chk("R10 stat", status_word, 32'hE800_0000);
    // R9 event beats clear
    step(1, 0, 32'hF800_0000, 4'h8, 5'b00001, 0, 0);
    chk("R9 win", status_word, 32'h0800_0000);
    // R10 status write leaves window
    step(0, 1, 0, 0, 0, 0, 0);
    chk("R10 win", reg_rdata, 32'hFFF0_FFF0);

    for (int i = 0; i < 3000; i++) begin
      logic wr, sel;
      logic [4:0] e0, e1;
      logic [31:0] a;
      logic [11:0] f;
      wr  = ($urandom % 3) == 0;
      sel = $urandom % 2;
      e0 = (($urandom % 6) == 0) ? 5'($urandom) : 5'b0;
      e1 = (($urandom % 6) == 0) ? 5'($urandom) : 5'b0;
      case ($urandom % 4)
        0: f = mb;
        1: f = ml;
        2: f = mb - 12'd1;
        default: f = ml + 12'd1;
      endcase
      case ($urandom % 3)
        0: a = {f, 20'h00000};
        1: a = {f, 20'hFFFFF};
        default: a = {f, 20'($urandom)};
      endcase
      if (($urandom % 8) == 0) a = $urandom;
      step(wr, sel, $urandom, 4'($urandom), e0, e1, a);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule